// File: doc/BRIEF.md
# Programmed Character I/O and Interrupt Flag Unit

This block sits beside a small accumulator processor and gives it one character input channel and one character output channel. Each channel holds an 8-bit character register and a ready flag. The flag is a handshake between the processor and an external device. A keyboard-like source may deposit a character only while the input flag is low, and doing so raises the flag. A printer-like sink may take the output character only while the output flag is low, and doing so raises the flag again.

On the processor side, the sequencer presents an execute strobe together with six one-hot operation bits taken from the instruction word. With these the block moves characters to and from the low byte of the accumulator, reports skip conditions, and turns the interrupt enable on or off. The interrupt enable gates both ready flags into a pending interrupt flag. That flag is armed only outside the fetch and decode steps, and it is cleared by the sequencer at the end of its interrupt cycle.

A device strobe that arrives when its flag does not allow it is dropped, and a one-cycle error pulse reports it.

Top module: `pio_intr_unit`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, the interrupt enable is 0, the pending interrupt is 0 and the error pulse is 0.
- R2: A device write strobe seen while the input flag is 0 stores the character, and from the next cycle the input flag is 1.
- R3: A device write strobe seen while the input flag is 1 is dropped, leaving the stored character unchanged. In the cycle after the strobe, the error output is 1 for exactly one cycle.
- R4: Operation bit 5 (instruction word 0xF800, input) drives acc_load_o high and puts the stored character on acc_data_o in the execute cycle. It clears the input flag from the next cycle. A device write in that same cycle, while the flag is still 1, is dropped as in R3.
- R5: Operation bit 4 (instruction word 0xF400, output) stores acc_lo_i as the output character and clears the output flag. Both changes show from the next cycle.
- R6: A device consume strobe seen while the output flag is 0 sets the output flag from the next cycle. Seen while the output flag is 1, it is dropped and gives the one-cycle error pulse.
- R7: In the execute cycle, pc_skip_o is 1 for operation bit 3 (0xF200) when the input flag is 1, and for operation bit 2 (0xF100) when the output flag is 1. Otherwise it is 0.
- R8: Operation bit 1 (0xF080) sets the interrupt enable and operation bit 0 (0xF040) clears it. Either change shows from the next cycle.
- R9: While fetch_phase_i is 0, the pending interrupt becomes 1 in the cycle after the interrupt enable is 1 together with either flag being 1. It never becomes 1 while fetch_phase_i is 1.
- R10: intr_done_i clears both the pending interrupt and the interrupt enable from the next cycle.
- R11: While io_exec_i is 0, the operation bits have no effect on any flag, character or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_wr_i | input | 1 | Device strobe offering a new input character |
| dev_wr_data_i | input | 8 | Character offered by the device |
| dev_rd_i | input | 1 | Device strobe taking the output character |
| dev_rd_data_o | output | 8 | Output character register |
| in_flag_o | output | 1 | Input ready flag |
| out_flag_o | output | 1 | Output ready flag |
| io_exec_i | input | 1 | Execute strobe for an I/O instruction |
| op_bits_i | input | 6 | Instruction bits 11..6: input, output, skip-in, skip-out, enable on, enable off |
| acc_lo_i | input | 8 | Accumulator low byte |
| acc_load_o | output | 1 | Load request for the accumulator low byte |
| acc_data_o | output | 8 | Input character toward the accumulator |
| pc_skip_o | output | 1 | Program counter increment request |
| fetch_phase_i | input | 1 | High during fetch and decode steps |
| intr_done_i | input | 1 | Last step of the interrupt cycle |
| ien_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Pending interrupt flag |
| strobe_err_o | output | 1 | One-cycle pulse for a dropped device strobe |

## Verification
acc_load_o, acc_data_o and pc_skip_o are combinational, so they are due in the execute cycle itself. The bench samples them one time unit after it drives the inputs at the falling edge. Every flag, character register, the interrupt enable, the pending interrupt and the error pulse change at the next rising edge. The bench checks these at the falling edge that follows, after returning the strobes to idle. For a dropped strobe it also checks one cycle later that the error pulse has gone low again. The bench checks that an interrupt stays unarmed by holding fetch_phase_i high for two cycles before releasing it, and then expects the pending flag one edge later.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int CHAR_W = 8;
  localparam int OP_W   = 6;
  // bit positions inside op_bits_i (instruction bits 11..6)
  localparam int OPB_IN   = 5;
  localparam int OPB_OUT  = 4;
  localparam int OPB_SKIN = 3;
  localparam int OPB_SKOUT= 2;
  localparam int OPB_EON  = 1;
  localparam int OPB_EOFF = 0;

  typedef struct packed {
    logic rd_in;
    logic wr_out;
    logic sk_in;
    logic sk_out;
    logic en_on;
    logic en_off;
  } io_cmd_t;
endpackage

// File: rtl/pio_in_chan.sv
module pio_in_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_i,
  output logic [W-1:0] data_o,
  output logic         flag_o,
  output logic         rej_o
);
  logic [W-1:0] data_q;
  logic         flag_q;
  logic         accept;

  assign accept = wr_i & ~flag_q;
  assign rej_o  = wr_i & flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= wr_data_i;
        flag_q <= 1'b1;
      end else if (clr_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;

  a_r2_write_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flag_q) |=> (flag_q && data_q == $past(wr_data_i)));
  a_r3_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && flag_q) |=> $stable(data_q));
  a_r4_read_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && flag_q) |=> !flag_q);
endmodule

// File: rtl/pio_out_chan.sv
module pio_out_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         ack_i,
  output logic [W-1:0] data_o,
  output logic         flag_o,
  output logic         rej_o
);
  logic [W-1:0] data_q;
  logic         flag_q;

  assign rej_o = ack_i & flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      flag_q <= 1'b1;
    end else begin
      // a fresh character keeps the sink busy even if it acks now
      if (load_i) begin
        data_q <= load_data_i;
        flag_q <= 1'b0;
      end else if (ack_i && !flag_q) begin
        flag_q <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;

  a_r5_load_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!flag_q && data_q == $past(load_data_i)));
  a_r6_ack_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !flag_q && !load_i) |=> flag_q);
endmodule

// File: rtl/pio_irq_ctl.sv
module pio_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_on_i,
  input  logic en_off_i,
  input  logic done_i,
  input  logic any_flag_i,
  input  logic fetch_i,
  output logic ien_o,
  output logic irq_o
);
  logic ien_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (done_i || en_off_i) ien_q <= 1'b0;
      else if (en_on_i)       ien_q <= 1'b1;
      if (done_i)                                   irq_q <= 1'b0;
      else if (ien_q && any_flag_i && !fetch_i)     irq_q <= 1'b1;
    end
  end

  assign ien_o = ien_q;
  assign irq_o = irq_q;

  a_r8_enable_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_on_i && !en_off_i && !done_i) |=> ien_q);
  a_r9_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q && any_flag_i && !fetch_i && !done_i) |=> irq_q);
  a_r9_no_arm_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && fetch_i) |=> !irq_q);
  a_r10_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!irq_q && !ien_q));
endmodule

// File: rtl/pio_intr_unit.sv
module pio_intr_unit
  import pio_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_wr_i,
  input  logic [CW-1:0] dev_wr_data_i,
  input  logic          dev_rd_i,
  output logic [CW-1:0] dev_rd_data_o,
  output logic          in_flag_o,
  output logic          out_flag_o,
  input  logic          io_exec_i,
  input  logic [OP_W-1:0] op_bits_i,
  input  logic [CW-1:0] acc_lo_i,
  output logic          acc_load_o,
  output logic [CW-1:0] acc_data_o,
  output logic          pc_skip_o,
  input  logic          fetch_phase_i,
  input  logic          intr_done_i,
  output logic          ien_o,
  output logic          irq_o,
  output logic          strobe_err_o
);
  io_cmd_t cmd;
  logic in_flag, out_flag, in_rej, out_rej, err_q;

  always_comb begin
    cmd        = '0;
    cmd.rd_in  = io_exec_i & op_bits_i[OPB_IN];
    cmd.wr_out = io_exec_i & op_bits_i[OPB_OUT];
    cmd.sk_in  = io_exec_i & op_bits_i[OPB_SKIN];
    cmd.sk_out = io_exec_i & op_bits_i[OPB_SKOUT];
    cmd.en_on  = io_exec_i & op_bits_i[OPB_EON];
    cmd.en_off = io_exec_i & op_bits_i[OPB_EOFF];
  end

  pio_in_chan #(.W(CW)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(dev_wr_i), .wr_data_i(dev_wr_data_i), .clr_i(cmd.rd_in),
    .data_o(acc_data_o), .flag_o(in_flag), .rej_o(in_rej)
  );

  pio_out_chan #(.W(CW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(cmd.wr_out), .load_data_i(acc_lo_i), .ack_i(dev_rd_i),
    .data_o(dev_rd_data_o), .flag_o(out_flag), .rej_o(out_rej)
  );

  pio_irq_ctl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_on_i(cmd.en_on), .en_off_i(cmd.en_off), .done_i(intr_done_i),
    .any_flag_i(in_flag | out_flag), .fetch_i(fetch_phase_i),
    .ien_o(ien_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= in_rej | out_rej;
  end

  assign acc_load_o   = cmd.rd_in;
  assign pc_skip_o    = (cmd.sk_in & in_flag) | (cmd.sk_out & out_flag);
  assign in_flag_o    = in_flag;
  assign out_flag_o   = out_flag;
  assign strobe_err_o = err_q;

  a_r7_skip_needs_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_skip_o |-> io_exec_i);
  a_r11_idle_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_exec_i |-> !acc_load_o);
  a_r3_err_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_i && in_flag) |=> strobe_err_o);
  a_r6_err_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_i && out_flag) |=> strobe_err_o);
endmodule

// File: tb/pio_intr_unit_tb.sv
module pio_intr_unit_tb;
  localparam time CLK_P = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       dev_wr = 0, dev_rd = 0, io_exec = 0, fetch = 0, done = 0;
  logic [7:0] dev_wr_data = '0, acc_lo = '0;
  logic [5:0] op = '0;
  logic [7:0] dev_rd_data, acc_data;
  logic       in_flag, out_flag, acc_load, pc_skip, ien, irq, serr;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pio_intr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dev_wr_i(dev_wr), .dev_wr_data_i(dev_wr_data),
    .dev_rd_i(dev_rd), .dev_rd_data_o(dev_rd_data),
    .in_flag_o(in_flag), .out_flag_o(out_flag),
    .io_exec_i(io_exec), .op_bits_i(op), .acc_lo_i(acc_lo),
    .acc_load_o(acc_load), .acc_data_o(acc_data), .pc_skip_o(pc_skip),
    .fetch_phase_i(fetch), .intr_done_i(done),
    .ien_o(ien), .irq_o(irq), .strobe_err_o(serr)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    dev_wr = 0; dev_rd = 0; io_exec = 0; op = '0; done = 0;
  endtask

  task automatic t_reset();
    chk("R1 in flag", in_flag, 0);
    chk("R1 out flag", out_flag, 1);
    chk("R1 ien", ien, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", serr, 0);
  endtask

  task automatic t_dev_write();
    @(negedge clk); dev_wr = 1; dev_wr_data = 8'h41;
    @(negedge clk); idle(); #1;
    chk("R2 in flag set", in_flag, 1);
    chk("R2 no err", serr, 0);
  endtask

  task automatic t_full_write();
    @(negedge clk); dev_wr = 1; dev_wr_data = 8'h55;
    @(negedge clk); idle(); #1;
    chk("R3 err pulse", serr, 1);
    chk("R3 flag held", in_flag, 1);
    @(negedge clk); #1;
    chk("R3 err one cycle", serr, 0);
  endtask

  task automatic t_read_race();
    @(negedge clk); io_exec = 1; op = 6'b100000; dev_wr = 1; dev_wr_data = 8'h77; #1;
    chk("R4 acc load", acc_load, 1);
    chk("R3 R4 char kept", acc_data, 8'h41);
    @(negedge clk); idle(); #1;
    chk("R4 flag cleared", in_flag, 0);
    chk("R4 racing write dropped", serr, 1);
    @(negedge clk); dev_wr = 1; dev_wr_data = 8'h77;
    @(negedge clk); idle(); #1;
    chk("R2 second write", in_flag, 1);
    chk("R2 second char", acc_data, 8'h77);
  endtask

  task automatic t_skips_full();
    @(negedge clk); io_exec = 1; op = 6'b001000; #1;
    chk("R7 skip in", pc_skip, 1);
    op = 6'b000100; #1;
    chk("R7 skip out", pc_skip, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_output();
    @(negedge clk); io_exec = 1; op = 6'b010000; acc_lo = 8'hA5;
    @(negedge clk); idle(); #1;
    chk("R5 out char", dev_rd_data, 8'hA5);
    chk("R5 out flag clear", out_flag, 0);
    io_exec = 1; op = 6'b000100; #1;
    chk("R7 no skip out", pc_skip, 0);
    @(negedge clk); idle(); dev_rd = 1;
    @(negedge clk); idle(); #1;
    chk("R6 consume sets flag", out_flag, 1);
    chk("R6 no err", serr, 0);
    dev_rd = 1;
    @(negedge clk); idle(); #1;
    chk("R6 extra consume err", serr, 1);
    chk("R6 flag stays", out_flag, 1);
  endtask

  task automatic t_not_exec();
    @(negedge clk); io_exec = 0; op = 6'b111111; acc_lo = 8'h3C; #1;
    chk("R11 no load", acc_load, 0);
    chk("R11 no skip", pc_skip, 0);
    @(negedge clk); idle(); #1;
    chk("R11 in flag", in_flag, 1);
    chk("R11 out flag", out_flag, 1);
    chk("R11 out char", dev_rd_data, 8'hA5);
    chk("R11 ien", ien, 0);
  endtask

  task automatic t_interrupt();
    @(negedge clk); fetch = 1; io_exec = 1; op = 6'b000010;
    @(negedge clk); idle(); #1;
    chk("R8 ien on", ien, 1);
    chk("R9 no arm in fetch", irq, 0);
    @(negedge clk); #1;
    chk("R9 still unarmed", irq, 0);
    fetch = 0;
    @(negedge clk); #1;
    chk("R9 armed", irq, 1);
    done = 1;
    @(negedge clk); idle(); #1;
    chk("R10 irq cleared", irq, 0);
    chk("R10 ien cleared", ien, 0);
    fetch = 1;
    @(negedge clk); io_exec = 1; op = 6'b000010;
    @(negedge clk); idle(); io_exec = 1; op = 6'b000001;
    @(negedge clk); idle(); #1;
    chk("R8 ien off", ien, 0);
    fetch = 0;
    @(negedge clk); #1;
    chk("R9 no arm without enable", irq, 0);
  endtask

  initial begin
    #(CLK_P*5000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_ni = 1;
    t_dev_write();
    t_full_write();
    t_read_race();
    t_skips_full();
    t_output();
    t_not_exec();
    t_interrupt();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule